// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch

This block chooses which of four source clocks drives the system clock. Software writes a 3-bit select code. The block moves the system clock to the requested source without producing a shortened high or low phase. A switch begins only when the requested source reports that it is stable. Until then the system clock keeps running on the source it already uses. A status bit stays high for as long as the running source does not match the select code.

The switch follows a break-before-make sequence. A sequencer runs on a control clock and removes the enable request of the old source. It waits until the old source confirms that its gate is closed, then raises the request for the new source and waits until that source confirms its gate is open. Each gate is a short chain of flops clocked on the falling edge of its own source. A gate therefore opens or closes only while its clock is low. Because the enables never overlap, every high pulse at the output is a complete high phase of exactly one source.

On leaving reset the select register is loaded from a boot-configuration input. That input picks either the crystal code or the internal fast RC code. The boot source is then brought up through the same sequence as any other switch.

Top module: `sysclk_switch`

## Requirements
- R1: The select code maps to a source as follows: 3'b000 selects source 0 (crystal), 3'b010 selects source 1 (PLL), 3'b011 selects source 2 (slow RC) and 3'b111 selects source 3 (fast RC). Once a switch is complete, `active_o` has only that source's bit set, and the output clock runs at that source's rate.
- R2: While reset is held and in the first cycle after it, `active_o` is 0 and `switch_fail_o` is 1. On leaving reset, the select register takes 3'b111 if `boot_hirc_i` is 1 and 3'b000 if it is 0, and that source is then brought up.
- R3: When the requested source's stable flag is 0, the output keeps running on the old source and `active_o` does not change, however long the wait lasts. No timeout applies. When the flag later rises, the switch completes without a new write.
- R4: `switch_fail_o` is 1 whenever the running source differs from the selected one, including while a switch is pending or in progress. It is 0 once the selected source is running.
- R5: A reserved select code (3'b001, 3'b100, 3'b101 or 3'b110) leaves the running source unchanged and drives `switch_fail_o` to 1.
- R6: Every high pulse of `sys_clk_o` lasts exactly one full high phase of some source, and at most one bit of `active_o` is set at any time.
- R7: During a switch, `active_o` becomes all zero before the new source's bit is set. A source's enable request rises only after every gate has been seen closed.
- R8: A select written while a switch is still in progress takes effect after that switch completes. The block ends on the most recently written source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk_i | input | 1 | Control clock for the select register and the sequencer |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| boot_hirc_i | input | 1 | Boot configuration: 1 loads 3'b111, 0 loads 3'b000 on leaving reset |
| sel_we_i | input | 1 | Write strobe for the select register |
| sel_wdata_i | input | 3 | Select code to write |
| src_clk_i | input | 4 | Source clocks; bit n is source n |
| src_stable_i | input | 4 | Stable flag for each source |
| sys_clk_o | output | 1 | Switched system clock |
| active_o | output | 4 | One-hot flag of the source whose gate is open (0 during a hand-over) |
| switch_fail_o | output | 1 | 1 while the running source does not match the select code |

## Verification
A new select write can land in the same control cycle in which the sequencer is already tearing down or raising an earlier switch. The block must then finish the switch in flight before it starts the new one. The bench provokes this by writing the slow RC code and then, on the very next cycle, the fast RC code. It judges the result by the final one-hot value and the fail bit, by the all-zero gap seen on `active_o`, and by measuring that no output high pulse deviates from any source's half period. A second overlap is tested by raising a held-off source's stable flag with no new write: the switch that was pending must then complete on its own.

// File: rtl/sysclk_sw_pkg.sv
package sysclk_sw_pkg;

    localparam int NSRC  = 4;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] CODE_XTAL = 3'b000;
    localparam logic [SEL_W-1:0] CODE_PLL  = 3'b010;
    localparam logic [SEL_W-1:0] CODE_LRC  = 3'b011;
    localparam logic [SEL_W-1:0] CODE_HRC  = 3'b111;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_SETTLED,
        ST_DROP,
        ST_RAISE
    } sw_state_e;

    typedef struct packed {
        logic            valid;
        logic [NSRC-1:0] oh;
    } sel_dec_t;

    typedef struct packed {
        sw_state_e        st;
        logic [SEL_W-1:0] sel;
        logic [NSRC-1:0]  cur;
        logic [NSRC-1:0]  nxt;
        logic [NSRC-1:0]  req;
    } seq_state_t;

    // Map a select code to a one-hot source vector; reserved codes are invalid.
    function automatic sel_dec_t decode_sel(input logic [SEL_W-1:0] code);
        sel_dec_t r;
        r.valid = 1'b1;
        r.oh    = '0;
        case (code)
            CODE_XTAL: r.oh[0] = 1'b1;
            CODE_PLL:  r.oh[1] = 1'b1;
            CODE_LRC:  r.oh[2] = 1'b1;
            CODE_HRC:  r.oh[3] = 1'b1;
            default:   r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sysclk_sw_sync.sv
module sysclk_sw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] pipe_d;
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q_o = pipe_q[LAST];

endmodule

// File: rtl/sysclk_sw_gate.sv
module sysclk_sw_gate #(
    parameter int STAGES = 2
) (
    input  logic src_clk_i,
    input  logic rst_n_i,
    input  logic req_i,
    output logic gate_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = req_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    // Falling-edge chain: the gate changes only while the source clock is low.
    always_ff @(negedge src_clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign gate_o = chain_q[LAST];

endmodule

// File: rtl/sysclk_sw_seq.sv
module sysclk_sw_seq
    import sysclk_sw_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             boot_hirc_i,
    input  logic             sel_we_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    input  logic [NSRC-1:0]  stab_s_i,
    input  logic [NSRC-1:0]  ack_s_i,
    output logic [NSRC-1:0]  req_o,
    output logic             fail_o
);
    localparam logic [SEL_W-1:0] BOOT_ALT = CODE_HRC;
    localparam logic [SEL_W-1:0] BOOT_DEF = CODE_XTAL;

    seq_state_t      q;
    seq_state_t      d;
    sel_dec_t        dec;
    logic [NSRC-1:0] req_q;
    logic            target_new;
    logic            target_ready;

    assign dec          = decode_sel(q.sel);
    assign target_new   = |(dec.oh & ~q.cur);
    assign target_ready = |(dec.oh & stab_s_i);

    always_comb begin
        d = q;

        if (q.st == ST_BOOT) begin
            d.sel = boot_hirc_i ? BOOT_ALT : BOOT_DEF;
        end else if (sel_we_i) begin
            d.sel = sel_wdata_i;
        end

        case (q.st)
            ST_BOOT: begin
                d.st = ST_SETTLED;
            end
            ST_SETTLED: begin
                if (dec.valid && target_new && target_ready) begin
                    d.req = '0;
                    d.nxt = dec.oh;
                    d.st  = ST_DROP;
                end
            end
            ST_DROP: begin
                if (ack_s_i == '0) begin
                    d.req = q.nxt;
                    d.st  = ST_RAISE;
                end
            end
            ST_RAISE: begin
                if (|(ack_s_i & q.nxt)) begin
                    d.cur = q.nxt;
                    d.st  = ST_SETTLED;
                end
            end
            default: begin
                d.st = ST_SETTLED;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            q <= '{st: ST_BOOT, sel: '0, cur: '0, nxt: '0, req: '0};
        end else begin
            q <= d;
        end
    end

    assign req_q  = q.req;
    assign req_o  = req_q;
    assign fail_o = !((q.st == ST_SETTLED) && dec.valid && (dec.oh == q.cur));

    // R6: gate acknowledgements from separate domains never overlap.
    p_active_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(ack_s_i));

    // R4: a clear status means the open gate is the selected source.
    p_match_when_ok_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !fail_o |-> (ack_s_i == dec.oh));

    // R5: a reserved code never starts a hand-over.
    p_reserved_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (q.st == ST_SETTLED && !dec.valid) |=> $stable(req_q));

    // R3: an unstable target never disturbs the running source.
    p_pending_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (q.st == ST_SETTLED && !target_ready) |=> $stable(req_q));

    // R7: a request rises only after every gate was seen closed.
    p_break_before_make_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ((req_q & ~$past(req_q)) != '0) |-> ($past(ack_s_i) == '0));

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import sysclk_sw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             ctl_clk_i,
    input  logic             rst_n_i,
    input  logic             boot_hirc_i,
    input  logic             sel_we_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    input  logic [NSRC-1:0]  src_clk_i,
    input  logic [NSRC-1:0]  src_stable_i,
    output logic             sys_clk_o,
    output logic [NSRC-1:0]  active_o,
    output logic             switch_fail_o
);
    logic [NSRC-1:0] stab_s;
    logic [NSRC-1:0] ack_s;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] gate;

    sysclk_sw_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_stab_sync (
        .clk_i   (ctl_clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (src_stable_i),
        .q_o     (stab_s)
    );

    sysclk_sw_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk_i   (ctl_clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (gate),
        .q_o     (ack_s)
    );

    sysclk_sw_seq u_seq (
        .clk_i       (ctl_clk_i),
        .rst_n_i     (rst_n_i),
        .boot_hirc_i (boot_hirc_i),
        .sel_we_i    (sel_we_i),
        .sel_wdata_i (sel_wdata_i),
        .stab_s_i    (stab_s),
        .ack_s_i     (ack_s),
        .req_o       (req),
        .fail_o      (switch_fail_o)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        sysclk_sw_gate #(.STAGES(SYNC_STAGES)) u_gate (
            .src_clk_i (src_clk_i[i]),
            .rst_n_i   (rst_n_i),
            .req_i     (req[i]),
            .gate_o    (gate[i])
        );
    end

    always_comb begin
        sys_clk_o = |(src_clk_i & gate);
    end

    assign active_o = ack_s;

endmodule

// File: tb/sim_sysclk_switch.sv
`timescale 1ns/1ps
module sim_sysclk_switch;

    typedef struct {
        string      tag;
        logic [3:0] act;
        logic       fail;
        real        half;
        int         cyc;
        bit         bbm;
    } exp_t;

    logic       ctl_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_hirc = 1'b0;
    logic       sel_we = 1'b0;
    logic [2:0] sel_wdata = 3'b000;
    logic       s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [3:0] src_clk;
    logic [3:0] src_stable = 4'b1111;
    logic       sys_clk;
    logic [3:0] active;
    logic       sw_fail;

    real HALF [4] = '{5.0, 3.0, 20.0, 9.0};

    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    int   runts  = 0;
    int   pulses = 0;
    bit   busy   = 0;
    bit   glitch_en = 0;
    bit   rise_ok = 0;
    real  t_rise = 0.0;
    exp_t sb [$];

    assign src_clk = {s3, s2, s1, s0};

    always #4 ctl_clk = ~ctl_clk;
    always #5.0  s0 = ~s0;
    always #3.0  s1 = ~s1;
    always #20.0 s2 = ~s2;
    always #9.0  s3 = ~s3;

    sysclk_switch u0 (
        .ctl_clk_i     (ctl_clk),
        .rst_n_i       (rst_n),
        .boot_hirc_i   (boot_hirc),
        .sel_we_i      (sel_we),
        .sel_wdata_i   (sel_wdata),
        .src_clk_i     (src_clk),
        .src_stable_i  (src_stable),
        .sys_clk_o     (sys_clk),
        .active_o      (active),
        .switch_fail_o (sw_fail)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge ctl_clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cycles, 150000);
            finish_run();
        end
    end

    // R6: every output high pulse must be one full source high phase.
    always @(posedge sys_clk) begin
        if (glitch_en) begin
            t_rise  = $realtime;
            rise_ok = 1;
        end
    end

    always @(negedge sys_clk) begin
        if (glitch_en && rise_ok) begin
            real w;
            bit  hit;
            w   = $realtime - t_rise;
            hit = 0;
            for (int k = 0; k < 4; k++) begin
                if (w > HALF[k] - 0.01 && w < HALF[k] + 0.01) hit = 1;
            end
            pulses++;
            if (!hit) runts++;
        end
        rise_ok = 0;
    end

    // Monitor: pops expected items and compares once the switch has had time.
    initial begin
        forever begin
            @(negedge ctl_clk);
            if (sb.size() > 0) begin
                exp_t e;
                bit   seen_zero;
                real  tr;
                real  w;
                e = sb.pop_front();
                busy = 1;
                seen_zero = 0;
                for (int c = 0; c < e.cyc; c++) begin
                    @(negedge ctl_clk);
                    if (active == 4'b0000) seen_zero = 1;
                end
                chk(active == e.act, e.tag, "active_o", int'(active), int'(e.act));
                chk(sw_fail == e.fail, e.tag, "switch_fail_o", int'(sw_fail), int'(e.fail));
                if (e.bbm) begin
                    chk(seen_zero, "R7", "all-zero gap during hand-over", int'(seen_zero), 1);
                end
                @(posedge sys_clk);
                tr = $realtime;
                @(negedge sys_clk);
                w = $realtime - tr;
                chk(w > e.half - 0.01 && w < e.half + 0.01, e.tag,
                    "high phase ps", int'(w * 1000.0), int'(e.half * 1000.0));
                busy = 0;
            end
        end
    end

    task automatic wait_idle();
        @(negedge ctl_clk);
        while (sb.size() != 0 || busy) @(negedge ctl_clk);
    endtask

    task automatic expect_state(input string tag, input logic [3:0] act,
                                input logic fail, input int src, input int cyc,
                                input bit bbm);
        exp_t e;
        e.tag = tag; e.act = act; e.fail = fail; e.half = HALF[src];
        e.cyc = cyc; e.bbm = bbm;
        sb.push_back(e);
        wait_idle();
    endtask

    task automatic write_sel(input logic [2:0] code);
        @(negedge ctl_clk);
        sel_we = 1'b1;
        sel_wdata = code;
        @(negedge ctl_clk);
        sel_we = 1'b0;
    endtask

    task automatic do_reset(input logic boot);
        glitch_en = 0;
        @(negedge ctl_clk);
        rst_n = 1'b0;
        boot_hirc = boot;
        repeat (5) @(negedge ctl_clk);
        chk(active == 4'b0000, "R2", "active_o in reset", int'(active), 0);
        chk(sw_fail == 1'b1, "R2", "switch_fail_o in reset", int'(sw_fail), 1);
        rst_n = 1'b1;
        @(negedge ctl_clk);
        chk(active == 4'b0000, "R2", "active_o after release", int'(active), 0);
        chk(sw_fail == 1'b1, "R2", "switch_fail_o after release", int'(sw_fail), 1);
        glitch_en = 1;
    endtask

    initial begin
        do_reset(1'b0);
        expect_state("R2", 4'b0001, 1'b0, 0, 200, 0);

        write_sel(3'b010);
        expect_state("R1", 4'b0010, 1'b0, 1, 200, 1);
        write_sel(3'b011);
        expect_state("R1", 4'b0100, 1'b0, 2, 200, 1);
        write_sel(3'b111);
        expect_state("R1", 4'b1000, 1'b0, 3, 200, 1);

        write_sel(3'b001);
        expect_state("R5", 4'b1000, 1'b1, 3, 200, 0);
        write_sel(3'b101);
        expect_state("R5", 4'b1000, 1'b1, 3, 200, 0);

        write_sel(3'b000);
        expect_state("R4", 4'b0001, 1'b0, 0, 200, 1);

        // R3: target not stable, long hold with no timeout.
        src_stable[1] = 1'b0;
        write_sel(3'b010);
        expect_state("R3", 4'b0001, 1'b1, 0, 2000, 0);
        src_stable[1] = 1'b1;
        expect_state("R3", 4'b0010, 1'b0, 1, 200, 1);

        // R8: second write lands while the first hand-over is in flight.
        @(negedge ctl_clk);
        sel_we = 1'b1;
        sel_wdata = 3'b011;
        @(negedge ctl_clk);
        sel_wdata = 3'b111;
        @(negedge ctl_clk);
        sel_we = 1'b0;
        expect_state("R8", 4'b1000, 1'b0, 3, 300, 1);

        do_reset(1'b1);
        expect_state("R2", 4'b1000, 1'b0, 3, 200, 0);

        chk(runts == 0, "R6", "runt high pulses", runts, 0);
        chk(pulses > 100, "R6", "pulses observed", pulses, 101);
        finish_run();
    end

endmodule